// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (I2C-style, SCL and SDA). It holds a small bank of byte-wide configuration registers and shows all of them at once on a parallel output bus, so the logic around it can read its settings directly. A bus master sets the registers through write transfers and reads them back through read transfers. Single registers can be reached at any pointer value, and longer runs use an auto-advancing pointer.

Both bus lines are brought into the system clock domain through a short synchroniser. The block finds START, repeated START and STOP on the synchronised lines. It compares the 7-bit device address: the upper five bits are fixed, and the lower two come from strap inputs, so four copies can share one bus. In a write, the byte after the address loads the register pointer and the bytes after that land in the registers. In a read, the block shifts registers out MSB first. The block only ever pulls SDA low: `sda_oe_o` high means "drive the line to 0". No transfer at the block's edge carries a valid/ready handshake, because the bus protocol itself paces every byte and the block never stalls the bus.

Top module: `i2c_cfg_bank`

## Requirements
- R1: A START (SDA falling while SCL is high) or repeated START restarts address reception from any state. A STOP (SDA rising while SCL is high) returns the block to idle. Both release SDA.
- R2: The device address is A6..A0 = 1,0,1,1,0,strap_i[1],strap_i[0], followed by an R/W bit (0 = write, 1 = read). On a match the block pulls SDA low for the whole high phase of the ninth SCL pulse.
- R3: When the address does not match, the block gives no acknowledge. It keeps SDA released, changes no register, and ignores traffic until the next START.
- R4: In a write, the byte after the address loads the register pointer from its bits [2:0]. Bits [7:3] are ignored. The byte is acknowledged.
- R5: Each later write byte goes into the register the pointer selects and is acknowledged. The pointer then advances modulo 8, so a register 7 write is followed by register 0.
- R6: If a STOP or repeated START arrives before all eight bits of a write data byte have been taken, no register changes.
- R7: In a read, the block sends the register at the pointer, MSB first, and then advances the pointer modulo 8. While the master acknowledges, the block sends the next register. A read starts at the pointer left by the last write transfer.
- R8: When the master does not acknowledge a read byte, the block keeps SDA released until the next START or STOP.
- R9: Register k appears on regs_o[8k+7:8k]. All registers reset to 0, and SDA is released in reset.
- R10: sda_oe_o changes only in the few system clocks after a synchronised SCL falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap_i | input | 2 | Low two device address bits (A1, A0) |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| regs_o | output | 64 | All eight registers, register k at bits [8k+7:8k] |

## Verification
The assertions assume SCL and SDA are quasi-static relative to the sampling clock. Each SCL phase must last several system clocks, and SDA must change only while SCL is low, except where the master deliberately makes a START or STOP. The stimulus drives every bus change on a falling system-clock edge and holds every SCL phase for six clocks. It also moves SDA one clock after SCL falls, so the synchronised lines never show a data change as a false START or STOP. The slave's pull-down is combined with the master's drive as a wired-AND, just like the real open-drain line.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_PTR,
    ST_ACK_P,
    ST_WDATA,
    ST_ACK_W,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  assert_start_needs_scl_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> (scl_s && $past(scl_s)));
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank #(
  parameter int NREG = 8,
  parameter int W    = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PW-1:0]   waddr,
  input  logic [W-1:0]    wdata,
  input  logic [PW-1:0]   raddr,
  output logic [W-1:0]    rdata,
  output logic [NREG*W-1:0] flat
);
  logic [W-1:0] regs_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[k] <= '0;
      else if (we && waddr == PW'(k)) regs_q[k] <= wdata;
    end
    assign flat[k*W +: W] = regs_q[k];
  end

  assign rdata = regs_q[raddr];

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> flat[$past(waddr)*W +: W] == $past(wdata));

  assert_no_write_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
  import tw_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int STRAP_W     = 2,
  parameter logic [6-STRAP_W:0] DEV_HI = 5'b10110,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [STRAP_W-1:0]     strap_i,
  output logic                   sda_oe_o,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  tw_state_e        state;
  logic [BIT_CW-1:0] bitcnt;
  logic [BYTE_W-1:0] rx, tx, rd_byte;
  logic [PW-1:0]     ptr;
  logic              mack, oe;
  logic              byte_end, wr_en, addr_hit;
  logic [PW-1:0]     ptr_next;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  assign byte_end = scl_fall && (bitcnt == BIT_CW'(BYTE_W));
  assign wr_en    = (state == ST_WDATA) && byte_end && !bus_start && !bus_stop;
  assign addr_hit = (rx[BYTE_W-1:1] == {DEV_HI, strap_i});
  assign ptr_next = (ptr == PW'(NREG-1)) ? '0 : ptr + 1'b1;

  tw_regbank #(.NREG(NREG), .W(BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(rx),
    .raddr(ptr), .rdata(rd_byte), .flat(regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      rx     <= '0;
      tx     <= '0;
      ptr    <= '0;
      mack   <= 1'b0;
      oe     <= 1'b0;
    end else if (bus_start) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else if (bus_stop) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && bitcnt < BIT_CW'(BYTE_W)) begin
            rx     <= {rx[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit) begin
                oe    <= 1'b1;
                mack  <= rx[0];
                state <= ST_ACK_A;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (state == ST_PTR) begin
              ptr   <= rx[PW-1:0];
              oe    <= 1'b1;
              state <= ST_ACK_P;
            end else begin
              ptr   <= ptr_next;
              oe    <= 1'b1;
              state <= ST_ACK_W;
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            if (mack) begin
              tx    <= rd_byte;
              oe    <= ~rd_byte[BYTE_W-1];
              state <= ST_RDATA;
            end else begin
              oe    <= 1'b0;
              state <= ST_PTR;
            end
          end
        end
        ST_ACK_P, ST_ACK_W: begin
          if (scl_fall) begin
            oe    <= 1'b0;
            state <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            bitcnt <= '0;
            oe     <= 1'b0;
            ptr    <= ptr_next;
            state  <= ST_RACK;
          end else if (scl_fall) begin
            tx <= {tx[BYTE_W-2:0], 1'b1};
            oe <= ~tx[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx    <= rd_byte;
              oe    <= ~rd_byte[BYTE_W-1];
              state <= ST_RDATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe;

  assert_oe_moves_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall || bus_start || bus_stop));

  assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK_A || state == ST_ACK_P || state == ST_ACK_W) |-> sda_oe_o);

  assert_ignore_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE && $past(state == ST_IGNORE)) |-> !sda_oe_o);

  assert_ptr_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> $past(scl_fall));

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe_o);
endmodule

// File: tb/tb_i2c_cfg_bank.sv
module tb_i2c_cfg_bank;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sda_oe;
  logic [63:0] regs;
  wire  sda_line = m_sda & ~sda_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit exp_release = 0;
  bit bus_evt = 0;
  int since_evt = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [8];
  int ptr_m = 0;

  always #2 clk = ~clk;

  i2c_cfg_bank dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = model[k];
    return f;
  endfunction

  // reference compared on every clock, away from the active edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      chk(regs === model_flat(), "R5/R6/R3 regs_o vs model", regs, model_flat());
      if (exp_release) chk(sda_oe === 1'b0, "R3/R8 SDA released", {63'b0, sda_oe}, 64'd0);
      if (bus_evt) begin
        since_evt = 0;
        bus_evt = 0;
      end else begin
        since_evt++;
      end
      if (sda_oe !== prev_oe)
        chk(since_evt <= 3, "R10 oe change timing", since_evt, 3);
      prev_oe = sda_oe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    m_sda = 1'b1; tick(1);
    scl = 1'b1; tick(P);
    m_sda = 1'b0; bus_evt = 1; tick(P);
    exp_release = 0;
    scl = 1'b0; bus_evt = 1; tick(P);
  endtask

  task automatic b_stop();
    m_sda = 1'b0; tick(P);
    scl = 1'b1; tick(P);
    m_sda = 1'b1; bus_evt = 1; tick(P);
    chk(sda_oe === 1'b0, "R1 released after STOP", {63'b0, sda_oe}, 64'd0);
  endtask

  task automatic b_rstart();
    m_sda = 1'b1; tick(P);
    scl = 1'b1; tick(P);
    m_sda = 1'b0; bus_evt = 1; tick(P);
    exp_release = 0;
    scl = 1'b0; bus_evt = 1; tick(P);
  endtask

  task automatic send_bit(input logic b, input bit commit, input int idx, input logic [7:0] val);
    m_sda = b; tick(P);
    scl = 1'b1; tick(P);
    scl = 1'b0; bus_evt = 1;
    if (commit) begin
      repeat (3) @(posedge clk);
      model[idx] = val;
    end
    tick(1);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit commit, input bit exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(v[i], commit && i == 0, ptr_m, v);
    m_sda = 1'b1; tick(P);
    scl = 1'b1; tick(P/2);
    chk(sda_line === ~exp_ack, tag, {63'b0, ~sda_line}, {63'b0, exp_ack});
    tick(P/2);
    scl = 1'b0; bus_evt = 1; tick(1);
  endtask

  task automatic read_byte(input bit mack, input string tag);
    logic [7:0] got;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(P);
      scl = 1'b1; tick(P/2);
      got[i] = sda_line;
      tick(P/2);
      scl = 1'b0; bus_evt = 1; tick(1);
    end
    chk(got === model[ptr_m], tag, got, model[ptr_m]);
    ptr_m = (ptr_m + 1) % 8;
    m_sda = mack ? 1'b0 : 1'b1; tick(P);
    scl = 1'b1; tick(P);
    scl = 1'b0; bus_evt = 1; tick(1);
    if (!mack) exp_release = 1;
  endtask

  task automatic part_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 0, 0, 8'h00);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    tick(5);
    chk(regs === 64'd0, "R9 regs reset", regs, 64'd0);
    chk(sda_oe === 1'b0, "R9 SDA released in reset", {63'b0, sda_oe}, 64'd0);
    rst_n = 1'b1;
    tick(4);

    // R2, R4, R5: address with strap 01, pointer upper bits ignored
    b_start();
    send_byte(8'b1011_0010, 0, 1, "R2 address ack");
    send_byte(8'hF3, 0, 1, "R4 pointer ack");
    ptr_m = 3;
    send_byte(8'hA5, 1, 1, "R5 data ack reg3");
    ptr_m = 4;
    send_byte(8'h3C, 1, 1, "R5 data ack reg4");
    ptr_m = 5;
    b_stop();

    // R5 wrap from register 6 through 7 into 0 and 1
    b_start();
    send_byte(8'b1011_0010, 0, 1, "R2 address ack");
    send_byte(8'h06, 0, 1, "R4 pointer ack");
    ptr_m = 6;
    for (int j = 0; j < 4; j++) begin
      send_byte(8'h11 * (j + 1), 1, 1, "R5 wrap data ack");
      ptr_m = (ptr_m + 1) % 8;
    end
    b_stop();

    // R6: STOP in the middle of a data byte
    b_start();
    send_byte(8'b1011_0010, 0, 1, "R2 address ack");
    send_byte(8'h02, 0, 1, "R4 pointer ack");
    part_bits(4);
    b_stop();

    // R6 and R1: repeated START mid byte, then read from pointer 5 (R7)
    b_start();
    send_byte(8'b1011_0010, 0, 1, "R2 address ack");
    send_byte(8'h05, 0, 1, "R4 pointer ack");
    ptr_m = 5;
    part_bits(5);
    b_rstart();
    send_byte(8'b1011_0011, 0, 1, "R1 address ack after repeated START");
    read_byte(1, "R7 read reg5 untouched");
    read_byte(0, "R8 read reg6 then NACK");
    part_bits(3);
    b_stop();

    // R7: read across the wrap after a pointer-only write
    b_start();
    send_byte(8'b1011_0010, 0, 1, "R2 address ack");
    send_byte(8'h06, 0, 1, "R4 pointer ack");
    ptr_m = 6;
    b_stop();
    b_start();
    send_byte(8'b1011_0011, 0, 1, "R7 read address ack");
    for (int j = 0; j < 3; j++) read_byte(1, "R7 sequential read");
    read_byte(0, "R8 last read NACK");
    b_stop();

    // R3: wrong address, nothing acked, nothing written
    b_start();
    send_byte(8'b1011_0100, 0, 0, "R3 no ack wrong address");
    exp_release = 1;
    send_byte(8'h00, 0, 0, "R3 no ack pointer");
    send_byte(8'hEE, 0, 0, "R3 no ack data");
    b_stop();

    // R2: other strap value
    strap = 2'b10;
    tick(4);
    b_start();
    send_byte(8'b1011_0100, 0, 1, "R2 address ack strap 10");
    send_byte(8'h00, 0, 1, "R4 pointer ack");
    ptr_m = 0;
    send_byte(8'h77, 1, 1, "R5 data ack reg0");
    b_stop();
    b_start();
    send_byte(8'b1011_0010, 0, 0, "R3 old strap address not acked");
    exp_release = 1;
    b_stop();
    tick(10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule